// File: doc/BRIEF.md
# Dual-Source Output Buffer Arbiter

This block sits between two byte sources, a keyboard-side source and an auxiliary (pointing-device) source, and the single output buffer that a host sees through its status and data ports. Each source raises a level input while it holds a byte. The block keeps a two-bit pending mask from those levels. From that mask it derives the buffer-full flags for the status register and the output port, and the two interrupt lines.

When both sources are pending, the keyboard source wins. The aux flags and the aux interrupt appear only when aux is the only source pending. The keyboard interrupt also depends on a keyboard-disable bit in the mode register. That register lives in the block. It is loaded by a mode write and changed by the keyboard enable and disable commands.

A host data-port read strobe produces a one-cycle pop on the source that the mask currently selects.

Top module: `obuf_arbiter`

## Requirements
- R1: Pending bit 0 (keyboard) and pending bit 1 (aux) each take the value of their level input (`kbd_avail_i`, `aux_avail_i`) on the next clock edge.
- R2: `stat_obf_o` and `port_obf_o` are high whenever at least one pending bit is set, and low otherwise. They follow the mask with no further delay.
- R3: `stat_aux_o` and `port_aux_o` are high only when the mask holds the aux bit alone. With both bits set they are low.
- R4: `irq_aux_o` is a register. It is loaded each cycle with (mask holds aux bit alone) AND mode bit 1, so it trails the mask and the mode register by one cycle.
- R5: `irq_kbd_o` is a register. It is loaded each cycle with (keyboard pending bit set) AND mode bit 0 AND NOT mode bit 4, so it trails the mask and the mode register by one cycle.
- R6: When `rd_stb_i` is sampled high, exactly one pop is high for the following cycle. `aux_pop_o` fires if the mask holds the aux bit alone. Otherwise `kbd_pop_o` fires, including when the mask is empty. Without a strobe, both pops are low.
- R7: When `mode_we_i` is high, `mode_wdata_i` replaces the mode register, and the new value is visible on `mode_o` after the edge.
- R8: `kbd_off_i` sets mode bit 4 and `kbd_on_i` clears it. If both are high together, `kbd_off_i` wins. A mode write in the same cycle overrides both.
- R9: After reset the mask is empty, all four buffer flags, both interrupts and both pops are low, and `mode_o` is 8'h03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kbd_avail_i | input | 1 | Keyboard source holds a byte (level) |
| aux_avail_i | input | 1 | Aux source holds a byte (level) |
| rd_stb_i | input | 1 | Host data-port read strobe |
| mode_we_i | input | 1 | Mode register write enable |
| mode_wdata_i | input | 8 | Mode register write value |
| kbd_off_i | input | 1 | Keyboard-disable command |
| kbd_on_i | input | 1 | Keyboard-enable command |
| mode_o | output | 8 | Current mode register |
| stat_obf_o | output | 1 | Status: output buffer full |
| stat_aux_o | output | 1 | Status: aux buffer full |
| port_obf_o | output | 1 | Output port mirror of buffer full |
| port_aux_o | output | 1 | Output port mirror of aux buffer full |
| irq_kbd_o | output | 1 | Keyboard interrupt level |
| irq_aux_o | output | 1 | Aux interrupt level |
| kbd_pop_o | output | 1 | Pop strobe to keyboard source |
| aux_pop_o | output | 1 | Pop strobe to aux source |

## Verification
The bench drives both sources pending at once. A design that let aux win, or raised the aux flags together with the keyboard flags, would show aux status or an aux pop where the keyboard is expected.

A read strobe with an empty mask must still pop the keyboard side. A design that stayed silent, or popped aux, is caught there.

The keyboard-disable bit is toggled while keyboard data is pending, and the enable and disable commands are issued together and alongside a mode write. A wrong priority leaves the interrupt or `mode_o` at the wrong value.

Interrupt timing is checked cycle by cycle against a one-cycle lag behind the mask. A combinational or two-stage interrupt shows up immediately.

// File: rtl/obuf_arb_pkg.sv
package obuf_arb_pkg;
  localparam int MODE_W   = 8;
  localparam int NSRC     = 2;
  localparam int SRC_KBD  = 0;
  localparam int SRC_AUX  = 1;
  localparam int M_KIE    = 0;
  localparam int M_AIE    = 1;
  localparam int M_KOFF   = 4;
  localparam logic [MODE_W-1:0] MODE_RST = 8'h03;

  typedef struct packed {
    logic any;       // some source pending
    logic aux_only;  // aux is sole pending source
    logic kbd_win;   // keyboard pending (wins ties)
  } obuf_view_t;
endpackage

// File: rtl/obuf_pend_mask.sv
module obuf_pend_mask #(
  parameter int N = obuf_arb_pkg::NSRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] mask_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_o[g] <= 1'b0;
      else         mask_o[g] <= lvl_i[g];
    end
  end
endmodule

// File: rtl/obuf_mode_reg.sv
module obuf_mode_reg #(
  parameter int W = obuf_arb_pkg::MODE_W,
  parameter logic [W-1:0] RST = obuf_arb_pkg::MODE_RST,
  parameter int OFF_BIT = obuf_arb_pkg::M_KOFF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         off_i,
  input  logic         on_i,
  output logic [W-1:0] mode_o
);
  logic [W-1:0] mode_d;

  always_comb begin
    mode_d = mode_o;
    if (we_i)       mode_d = wdata_i;
    else if (off_i) mode_d[OFF_BIT] = 1'b1;
    else if (on_i)  mode_d[OFF_BIT] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_o <= RST;
    else         mode_o <= mode_d;
  end
endmodule

// File: rtl/obuf_view_dec.sv
module obuf_view_dec
  import obuf_arb_pkg::*;
(
  input  logic [NSRC-1:0] mask_i,
  output obuf_view_t      view_o
);
  localparam logic [NSRC-1:0] AUX_ONLY = NSRC'(1) << SRC_AUX;

  always_comb begin
    view_o.any      = |mask_i;
    view_o.aux_only = (mask_i == AUX_ONLY);
    view_o.kbd_win  = mask_i[SRC_KBD];
  end
endmodule

// File: rtl/obuf_irq_pop.sv
module obuf_irq_pop
  import obuf_arb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  obuf_view_t view_i,
  input  logic       kie_i,
  input  logic       aie_i,
  input  logic       koff_i,
  input  logic       rd_stb_i,
  output logic       irq_kbd_o,
  output logic       irq_aux_o,
  output logic       kbd_pop_o,
  output logic       aux_pop_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_kbd_o <= 1'b0;
      irq_aux_o <= 1'b0;
      kbd_pop_o <= 1'b0;
      aux_pop_o <= 1'b0;
    end else begin
      irq_kbd_o <= view_i.kbd_win & kie_i & ~koff_i;
      irq_aux_o <= view_i.aux_only & aie_i;
      // anything but aux-alone routes to keyboard, including empty
      kbd_pop_o <= rd_stb_i & ~view_i.aux_only;
      aux_pop_o <= rd_stb_i & view_i.aux_only;
    end
  end
endmodule

// File: rtl/obuf_arbiter.sv
module obuf_arbiter
  import obuf_arb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kbd_avail_i,
  input  logic              aux_avail_i,
  input  logic              rd_stb_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              kbd_off_i,
  input  logic              kbd_on_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              stat_obf_o,
  output logic              stat_aux_o,
  output logic              port_obf_o,
  output logic              port_aux_o,
  output logic              irq_kbd_o,
  output logic              irq_aux_o,
  output logic              kbd_pop_o,
  output logic              aux_pop_o
);
  logic [NSRC-1:0] lvl, mask;
  obuf_view_t      view;

  always_comb begin
    lvl          = '0;
    lvl[SRC_KBD] = kbd_avail_i;
    lvl[SRC_AUX] = aux_avail_i;
  end

  obuf_pend_mask #(.N(NSRC)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .mask_o(mask)
  );

  obuf_mode_reg u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(mode_we_i), .wdata_i(mode_wdata_i),
    .off_i(kbd_off_i), .on_i(kbd_on_i), .mode_o(mode_o)
  );

  obuf_view_dec u_dec (.mask_i(mask), .view_o(view));

  obuf_irq_pop u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .view_i(view),
    .kie_i(mode_o[M_KIE]), .aie_i(mode_o[M_AIE]), .koff_i(mode_o[M_KOFF]),
    .rd_stb_i(rd_stb_i),
    .irq_kbd_o(irq_kbd_o), .irq_aux_o(irq_aux_o),
    .kbd_pop_o(kbd_pop_o), .aux_pop_o(aux_pop_o)
  );

  assign stat_obf_o = view.any;
  assign port_obf_o = view.any;
  assign stat_aux_o = view.aux_only;
  assign port_aux_o = view.aux_only;
endmodule

// File: rtl/obuf_arbiter_chk.sv
module obuf_arbiter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       kbd_avail_i,
  input logic       aux_avail_i,
  input logic       rd_stb_i,
  input logic       mode_we_i,
  input logic [7:0] mode_wdata_i,
  input logic       kbd_off_i,
  input logic       kbd_on_i,
  input logic [7:0] mode_o,
  input logic       stat_obf_o,
  input logic       stat_aux_o,
  input logic       port_obf_o,
  input logic       port_aux_o,
  input logic       irq_kbd_o,
  input logic       irq_aux_o,
  input logic       kbd_pop_o,
  input logic       aux_pop_o
);
  // R1
  kbd_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kbd_avail_i |=> (stat_obf_o && !stat_aux_o));
  // R3
  aux_needs_obf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_aux_o |-> port_obf_o);
  // R5
  kbd_irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_kbd_o) |-> ($past(mode_o[0]) && !$past(mode_o[4])));
  // R4
  irq_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({irq_kbd_o, irq_aux_o}));
  // R6
  pop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({kbd_pop_o, aux_pop_o}));
  // R6
  pop_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_i |=> (kbd_pop_o || aux_pop_o));
  // R8
  off_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kbd_off_i && !mode_we_i) |=> mode_o[4]);
endmodule

bind obuf_arbiter obuf_arbiter_chk u_chk (.*);

// File: tb/sim_obuf_arbiter.sv
`timescale 1ns/1ps
module sim_obuf_arbiter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic kbd_av = 0, aux_av = 0, rd = 0, mwe = 0, off = 0, on_c = 0;
  logic [7:0] mwd = '0;
  logic [7:0] mode;
  logic s_obf, s_aux, p_obf, p_aux, ik, ia, kp, ap;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // expected state
  logic [1:0] e_mask;
  logic [7:0] e_mode;
  logic e_ik, e_ia, e_kp, e_ap;

  always #2 clk = ~clk;

  obuf_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_n), .kbd_avail_i(kbd_av), .aux_avail_i(aux_av),
    .rd_stb_i(rd), .mode_we_i(mwe), .mode_wdata_i(mwd), .kbd_off_i(off),
    .kbd_on_i(on_c), .mode_o(mode), .stat_obf_o(s_obf), .stat_aux_o(s_aux),
    .port_obf_o(p_obf), .port_aux_o(p_aux), .irq_kbd_o(ik), .irq_aux_o(ia),
    .kbd_pop_o(kp), .aux_pop_o(ap)
  );

  function automatic logic f_any(logic [1:0] m); return |m; endfunction
  function automatic logic f_aux(logic [1:0] m); return m == 2'b10; endfunction

  task automatic chk(logic [7:0] act, logic [7:0] exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk({7'd0, s_obf}, {7'd0, f_any(e_mask)}, "R2 stat_obf");
    chk({7'd0, p_obf}, {7'd0, f_any(e_mask)}, "R2 port_obf");
    chk({7'd0, s_aux}, {7'd0, f_aux(e_mask)}, "R3 stat_aux");
    chk({7'd0, p_aux}, {7'd0, f_aux(e_mask)}, "R3 port_aux");
    chk({7'd0, ia}, {7'd0, e_ia}, "R4 irq_aux");
    chk({7'd0, ik}, {7'd0, e_ik}, "R5 irq_kbd");
    chk({6'd0, kp, ap}, {6'd0, e_kp, e_ap}, "R6 pops");
    chk(mode, e_mode, "R7 R8 mode");
  endtask

  // apply inputs for one cycle, advance model, check at next negedge
  task automatic cyc(logic k, logic a, logic r, logic we, logic [7:0] wd,
                     logic of, logic onn);
    logic [7:0] nm;
    kbd_av = k; aux_av = a; rd = r; mwe = we; mwd = wd; off = of; on_c = onn;
    @(posedge clk);
    e_ik = e_mask[0] & e_mode[0] & ~e_mode[4];
    e_ia = f_aux(e_mask) & e_mode[1];
    e_kp = r & ~f_aux(e_mask);
    e_ap = r & f_aux(e_mask);
    nm = e_mode;
    if (we) nm = wd;
    else if (of) nm[4] = 1'b1;
    else if (onn) nm[4] = 1'b0;
    e_mode = nm;
    e_mask = {a, k};
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    e_mask = 0; e_mode = 8'h03; e_ik = 0; e_ia = 0; e_kp = 0; e_ap = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check_all();
    rst_n = 1'b1;
    @(negedge clk);
    check_all();
    // R1 R2 R5 keyboard alone, irq lags mask
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    // R3 R6 both pending: keyboard wins on read
    cyc(1, 1, 1, 0, 0, 0, 0);
    cyc(0, 1, 1, 0, 0, 0, 0);
    // R4 R6 aux alone
    cyc(0, 1, 1, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 0);
    // R6 empty mask read pops keyboard
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0, 0);
    // R8 disable with keyboard pending, then both cmds: off wins
    cyc(1, 0, 0, 0, 0, 1, 0);
    cyc(1, 0, 0, 0, 0, 0, 1);
    cyc(1, 0, 0, 0, 0, 1, 1);
    cyc(1, 0, 0, 0, 0, 0, 0);
    // R7 R8 write overrides commands
    cyc(1, 0, 0, 1, 8'h01, 1, 0);
    cyc(0, 1, 0, 1, 8'h00, 0, 1);
    cyc(0, 1, 0, 1, 8'h02, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] w;
      w = 8'($urandom);
      cyc(1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 8) == 0, w,
          ($urandom % 6) == 0, ($urandom % 6) == 0);
    end
    // R9 reset mid-run
    rst_n = 1'b0;
    e_mask = 0; e_mode = 8'h03; e_ik = 0; e_ia = 0; e_kp = 0; e_ap = 0;
    kbd_av = 1; aux_av = 1;
    @(negedge clk);
    check_all();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule